// File: doc/BRIEF.md
# Sequential-Trigger Trace Capture

This block records bus samples (address, data, status) into a circular memory while it is armed. Every valid sample goes into the next slot, so the oldest history is always the next thing lost. A two-level trigger watches the same samples. The first level must match on some sample. Only after that is the second level evaluated, starting with the next sample. When the second level matches, that sample is the trigger.

After the trigger, capture goes on for a programmed number of further samples and then stops. The memory then holds the states that led up to the trigger and the states that followed it. How many of each it holds is set by the post-trigger count.

The trigger can raise a one-cycle break request so that the processor under observation can be halted. Once capture has stopped, the host reads the memory one entry at a time by index. It locates the trigger in the frozen history from the trigger slot index, the wrap flag and the current write index.

Top module: `trc_capture`

## Requirements
- R1: After reset, trig_fired, brk_req, frozen and wrapped are 0, and trig_idx, wr_idx and rd_data are 0. No capture takes place until the block is armed.
- R2: While capture is active, each cycle with smp_valid high stores {smp_addr, smp_data, smp_stat} at wr_idx. wr_idx starts at 0 on arm and counts modulo DEPTH. rd_data returns the entry at rd_idx one clock after rd_idx is applied, with the address in the top bits and the status in the bottom bits.
- R3: wrapped goes to 1 on the write into slot DEPTH-1 and stays at 1 until the next arm.
- R4: Each of the two terms of a level compares one field against bounds lo and hi. The mode codes are 0 = equal to lo, 1 = less than lo (unsigned), 2 = inside lo..hi inclusive, and 3 = always true. The field codes are 0 = address, 1 = data, 2 = status and 3 = address.
- R5: A level's combine bit selects AND (0) or OR (1) of its two terms.
- R6: The second level is evaluated only on samples after the one that satisfied the first level. A second-level match that comes earlier causes no trigger.
- R7: The trigger sample is written at the slot reported on trig_idx. trig_fired is high from the clock edge that stores the trigger sample.
- R8: With a post-trigger count N > 0, exactly N more valid samples are stored after the trigger. frozen rises on the edge that stores the last of them. Samples that arrive later change neither the memory nor wr_idx.
- R9: With a post-trigger count of 0, frozen rises on the edge that stores the trigger sample itself.
- R10: A post-trigger count larger than DEPTH is accepted. Capture continues through it and overwrites older entries, including the trigger sample.
- R11: When break is enabled, brk_req is a pulse exactly one cycle long in the cycle after the trigger edge. When break is disabled, brk_req stays 0.
- R12: Writing the control register with bit 0 = 1 arms the block. This clears wr_idx, wrapped, trig_idx, trig_fired and frozen and restarts the sequence at the first level. Writing bit 0 = 0 stops capture.
- R13: Configuration writes go to cfg_addr on a cycle with cfg_we high:
  - 0: control (bit 0 arm, bit 1 break enable).
  - 1: post-trigger count.
  - 2 + 4·level + 2·term: lo bound; the following address is the hi bound of the same term.
  - 10 and 11: setup of level 0 and level 1. Bits [1:0] are the field of term 0, [3:2] the mode of term 0, [5:4] the field of term 1, [7:6] the mode of term 1, and bit 8 is the combine bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample qualifier |
| smp_addr | input | AW | Sampled address |
| smp_data | input | DW | Sampled data |
| smp_stat | input | SW | Sampled status |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register select |
| cfg_wdata | input | CFG_W | Configuration write value |
| rd_idx | input | log2(DEPTH) | Readout slot index |
| rd_data | output | AW+DW+SW | Readout entry, one cycle after rd_idx |
| trig_fired | output | 1 | Trigger has occurred since arm |
| brk_req | output | 1 | One-cycle break request |
| frozen | output | 1 | Capture stopped after the post-trigger count |
| wrapped | output | 1 | Write index has rolled over since arm |
| trig_idx | output | log2(DEPTH) | Slot of the trigger sample |
| wr_idx | output | log2(DEPTH) | Next slot to be written |

## Verification
The trigger flag, the trigger index, the wrap flag, the write index and the frozen flag are all due at the first falling edge after the rising edge that stores the sample causing them. The bench drives each sample at a falling edge and checks these outputs at the next falling edge. The break pulse is checked at that same falling edge, and checked low one sample later. Readout data lags rd_idx by one clock. For this reason the read driver queues the expected entry when it applies the index, and a monitor compares it one falling edge later.

// File: rtl/trc_pkg.sv
package trc_pkg;

  localparam int CMP_MAX = 32;

  typedef enum logic [1:0] {
    CMP_EQ  = 2'd0,
    CMP_LT  = 2'd1,
    CMP_IN  = 2'd2,
    CMP_ANY = 2'd3
  } cmp_mode_e;

  typedef enum logic [1:0] {
    FLD_ADDR = 2'd0,
    FLD_DATA = 2'd1,
    FLD_STAT = 2'd2,
    FLD_ALT  = 2'd3
  } fld_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LV0,
    SQ_LV1,
    SQ_POST,
    SQ_HOLD
  } seq_e;

  // Setup word, bit 8 down to bit 0.
  typedef struct packed {
    logic      comb_or;
    cmp_mode_e m1;
    fld_e      f1;
    cmp_mode_e m0;
    fld_e      f0;
  } lvl_setup_t;

  function automatic logic term_hit(input cmp_mode_e m,
                                    input logic [CMP_MAX-1:0] v,
                                    input logic [CMP_MAX-1:0] lo,
                                    input logic [CMP_MAX-1:0] hi);
    logic r;
    case (m)
      CMP_EQ:  r = (v == lo);
      CMP_LT:  r = (v < lo);
      CMP_IN:  r = (v >= lo) && (v <= hi);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/trc_level.sv
module trc_level
  import trc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int SW = 4
) (
  input  logic [AW-1:0]                addr,
  input  logic [DW-1:0]                data,
  input  logic [SW-1:0]                stat,
  input  lvl_setup_t                   setup,
  input  logic [1:0][CMP_MAX-1:0]      lo,
  input  logic [1:0][CMP_MAX-1:0]      hi,
  output logic                         hit
);

  logic [1:0] term;

  for (genvar gi = 0; gi < 2; gi++) begin : g_term
    fld_e               sel;
    cmp_mode_e          md;
    logic [CMP_MAX-1:0] val;

    assign sel = (gi == 0) ? setup.f0 : setup.f1;
    assign md  = (gi == 0) ? setup.m0 : setup.m1;

    always_comb begin
      case (sel)
        FLD_DATA: val = CMP_MAX'(data);
        FLD_STAT: val = CMP_MAX'(stat);
        default:  val = CMP_MAX'(addr);
      endcase
    end

    assign term[gi] = term_hit(md, val, lo[gi], hi[gi]);
  end

  assign hit = setup.comb_or ? (|term) : (&term);

endmodule

// File: rtl/trc_seq.sv
module trc_seq
  import trc_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_ev,
  input  logic             stop_ev,
  input  logic             smp_valid,
  input  logic             hit0,
  input  logic             hit1,
  input  logic [CNT_W-1:0] post,
  output logic             cap_we,
  output logic             trig_ev,
  output logic             frozen,
  output logic             trig_fired
);

  seq_e             st;
  logic [CNT_W-1:0] rem;
  logic             capturing;

  function automatic logic post_last(input logic [CNT_W-1:0] r);
    return r == CNT_W'(1);
  endfunction

  assign capturing = (st == SQ_LV0) || (st == SQ_LV1) || (st == SQ_POST);
  assign cap_we    = smp_valid && capturing && !arm_ev && !stop_ev;
  assign trig_ev   = cap_we && (st == SQ_LV1) && hit1;
  assign frozen    = (st == SQ_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SQ_IDLE;
      rem        <= '0;
      trig_fired <= 1'b0;
    end else if (arm_ev) begin
      st         <= SQ_LV0;
      rem        <= '0;
      trig_fired <= 1'b0;
    end else if (stop_ev) begin
      st <= SQ_IDLE;
    end else if (cap_we) begin
      case (st)
        SQ_LV0: if (hit0) st <= SQ_LV1;
        SQ_LV1: if (trig_ev) begin
          trig_fired <= 1'b1;
          if (post == '0) st <= SQ_HOLD;
          else begin
            rem <= post;
            st  <= SQ_POST;
          end
        end
        SQ_POST: begin
          if (post_last(rem)) st <= SQ_HOLD;
          else rem <= rem - CNT_W'(1);
        end
        default: st <= st;
      endcase
    end
  end

endmodule

// File: rtl/trc_ring.sv
module trc_ring #(
  parameter int DEPTH = 16,
  parameter int RW    = 36,
  parameter int PW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [RW-1:0] wdata,
  input  logic          trig_ev,
  input  logic [PW-1:0] rd_idx,
  output logic [PW-1:0] wptr,
  output logic          wrapped,
  output logic [PW-1:0] trig_idx,
  output logic [RW-1:0] rd_data
);

  logic [RW-1:0] mem [DEPTH];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (we && !clr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      wrapped  <= 1'b0;
      trig_idx <= '0;
    end else if (clr) begin
      wptr     <= '0;
      wrapped  <= 1'b0;
      trig_idx <= '0;
    end else if (we) begin
      wptr <= step(wptr);
      if (wptr == PW'(DEPTH - 1)) wrapped <= 1'b1;
      if (trig_ev) trig_idx <= wptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/trc_capture.sv
module trc_capture
  import trc_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int SW     = 4,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 20,
  parameter int CFG_AW = 4,
  parameter int CFG_W  = 32,
  localparam int RW    = AW + DW + SW,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [AW-1:0]     smp_addr,
  input  logic [DW-1:0]     smp_data,
  input  logic [SW-1:0]     smp_stat,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [PW-1:0]     rd_idx,
  output logic [RW-1:0]     rd_data,
  output logic              trig_fired,
  output logic              brk_req,
  output logic              frozen,
  output logic              wrapped,
  output logic [PW-1:0]     trig_idx,
  output logic [PW-1:0]     wr_idx
);

  localparam logic [CFG_AW-1:0] A_CTRL = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] A_POST = CFG_AW'(1);
  localparam logic [CFG_AW-1:0] A_BLO  = CFG_AW'(2);
  localparam logic [CFG_AW-1:0] A_BHI  = CFG_AW'(9);
  localparam logic [CFG_AW-1:0] A_SET0 = CFG_AW'(10);
  localparam logic [CFG_AW-1:0] A_SET1 = CFG_AW'(11);

  logic                          brk_en;
  logic [CNT_W-1:0]              post_q;
  lvl_setup_t [1:0]              setup_q;
  logic [1:0][1:0][CMP_MAX-1:0]  lo_q;
  logic [1:0][1:0][CMP_MAX-1:0]  hi_q;
  logic [CFG_AW-1:0]             off;
  logic                          is_bound;

  // Named internal events, also observed by the bound checker.
  logic          arm_ev;
  logic          stop_ev;
  logic [1:0]    lvl_hit;
  logic          cap_we;
  logic          trig_ev;
  logic [PW-1:0] wptr;

  assign off      = cfg_addr - A_BLO;
  assign is_bound = (cfg_addr >= A_BLO) && (cfg_addr <= A_BHI);
  assign arm_ev   = cfg_we && (cfg_addr == A_CTRL) && cfg_wdata[0];
  assign stop_ev  = cfg_we && (cfg_addr == A_CTRL) && !cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_en  <= 1'b0;
      post_q  <= '0;
      setup_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_CTRL) brk_en <= cfg_wdata[1];
      else if (cfg_addr == A_POST) post_q <= CNT_W'(cfg_wdata);
      else if (is_bound) begin
        if (off[0]) hi_q[off[2]][off[1]] <= CMP_MAX'(cfg_wdata);
        else        lo_q[off[2]][off[1]] <= CMP_MAX'(cfg_wdata);
      end
      else if (cfg_addr == A_SET0) setup_q[0] <= lvl_setup_t'(cfg_wdata[8:0]);
      else if (cfg_addr == A_SET1) setup_q[1] <= lvl_setup_t'(cfg_wdata[8:0]);
    end
  end

  for (genvar lv = 0; lv < 2; lv++) begin : g_lvl
    trc_level #(.AW(AW), .DW(DW), .SW(SW)) u_lvl (
      .addr  (smp_addr),
      .data  (smp_data),
      .stat  (smp_stat),
      .setup (setup_q[lv]),
      .lo    (lo_q[lv]),
      .hi    (hi_q[lv]),
      .hit   (lvl_hit[lv])
    );
  end

  trc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_ev     (arm_ev),
    .stop_ev    (stop_ev),
    .smp_valid  (smp_valid),
    .hit0       (lvl_hit[0]),
    .hit1       (lvl_hit[1]),
    .post       (post_q),
    .cap_we     (cap_we),
    .trig_ev    (trig_ev),
    .frozen     (frozen),
    .trig_fired (trig_fired)
  );

  trc_ring #(.DEPTH(DEPTH), .RW(RW), .PW(PW)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (arm_ev),
    .we       (cap_we),
    .wdata    ({smp_addr, smp_data, smp_stat}),
    .trig_ev  (trig_ev),
    .rd_idx   (rd_idx),
    .wptr     (wptr),
    .wrapped  (wrapped),
    .trig_idx (trig_idx),
    .rd_data  (rd_data)
  );

  assign wr_idx = wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_req <= 1'b0;
    else        brk_req <= trig_ev && brk_en;
  end

endmodule

// File: rtl/trc_capture_chk.sv
module trc_capture_chk #(
  parameter int PW    = 4,
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm_ev,
  input logic             trig_ev,
  input logic             frozen,
  input logic             trig_fired,
  input logic             brk_req,
  input logic             wrapped,
  input logic [PW-1:0]    wptr,
  input logic [PW-1:0]    trig_idx,
  input logic [CNT_W-1:0] post_q
);

  p_brk_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);

  p_brk_after_trig_r11: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> trig_fired);

  p_frozen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !arm_ev) |=> $stable(wptr));

  p_wrap_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !arm_ev) |=> wrapped);

  p_arm_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ev |=> (wptr == '0 && !wrapped && !trig_fired && !frozen));

  p_post_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_ev && post_q == '0) |=> frozen);

  p_trig_idx_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ev |=> (trig_idx == $past(wptr)));

  p_trig_idx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_fired && !arm_ev) |=> $stable(trig_idx));

endmodule

bind trc_capture trc_capture_chk #(.PW(PW), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arm_ev     (arm_ev),
  .trig_ev    (trig_ev),
  .frozen     (frozen),
  .trig_fired (trig_fired),
  .brk_req    (brk_req),
  .wrapped    (wrapped),
  .wptr       (wptr),
  .trig_idx   (trig_idx),
  .post_q     (post_q)
);

// File: tb/sim_trc_capture.sv
`timescale 1ns/1ps
module sim_trc_capture;

  localparam int AW = 16, DW = 16, SW = 4, DEPTH = 16, CNT_W = 20;
  localparam int RW = AW + DW + SW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic [AW-1:0] smp_addr = '0;
  logic [DW-1:0] smp_data = '0;
  logic [SW-1:0] smp_stat = '0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [3:0]    rd_idx = '0;
  logic [RW-1:0] rd_data;
  logic          trig_fired, brk_req, frozen, wrapped;
  logic [3:0]    trig_idx, wr_idx;

  always #2.5 clk = ~clk;

  trc_capture #(.AW(AW), .DW(DW), .SW(SW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_addr(smp_addr),
    .smp_data(smp_data), .smp_stat(smp_stat), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_idx(rd_idx),
    .rd_data(rd_data), .trig_fired(trig_fired), .brk_req(brk_req),
    .frozen(frozen), .wrapped(wrapped), .trig_idx(trig_idx), .wr_idx(wr_idx)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [RW-1:0] hist [64];
  int ns = 0;

  logic [RW-1:0] exp_q [$];
  string         tag_q [$];
  logic          rd_go = 1'b0;
  logic          go_d = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic cfg(input int a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic arm(input bit brk);
    cfg(0, {30'b0, brk, 1'b1});
    ns = 0;
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [SW-1:0] s);
    smp_valid = 1'b1; smp_addr = a; smp_data = d; smp_stat = s;
    hist[ns] = {a, d, s};
    ns++;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // Driver side of the readout scoreboard.
  task automatic rd(input int idx, input logic [RW-1:0] exp, input string tag);
    rd_idx = 4'(idx);
    rd_go = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_go = 1'b0;
  endtask

  // Sample number held by slot idx when the last stored sample is number last.
  function automatic int slot_owner(input int idx, input int last);
    return last - ((last - idx + 4 * DEPTH) % DEPTH);
  endfunction

  always @(posedge clk) go_d <= rd_go;

  // Monitor side: entry is due one clock after the index.
  always @(negedge clk) begin
    if (go_d && exp_q.size() > 0) begin
      logic [RW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s: actual %0h expected %0h", t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual hang expected completion");
      finish_run();
    end
  end

  initial begin
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [SW-1:0] s;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 trig_fired", trig_fired, 0);
    chk("R1 brk_req", brk_req, 0);
    chk("R1 frozen", frozen, 0);
    chk("R1 wrapped", wrapped, 0);
    chk("R1 trig_idx", trig_idx, 0);
    chk("R1 wr_idx", wr_idx, 0);
    chk("R1 rd_data", rd_data, 0);

    // Test A: equal address, then data range AND status equal; post 3; break on
    cfg(2, 32'h0040);
    cfg(10, 32'h0C0);
    cfg(6, 32'h1000);
    cfg(7, 32'h10FF);
    cfg(8, 32'h0005);
    cfg(11, 32'h029);
    cfg(1, 3);
    arm(1'b1);
    for (int n = 0; n < 28; n++) begin
      a = 16'h0100 + 16'(n); d = 16'h2000 + 16'(n); s = {1'b0, 3'(n)};
      if (n == 2)  begin d = 16'h1010; s = 4'h5; end
      if (n == 5)  a = 16'h0040;
      if (n == 9)  begin d = 16'h1020; s = 4'h4; end
      if (n == 20) begin d = 16'h1005; s = 4'h5; end
      if (n >= 24) d = 16'hDEAD;
      send(a, d, s);
      if (n == 2)  chk("R6 early second-level match ignored", trig_fired, 0);
      if (n == 9)  chk("R5 AND needs both terms", trig_fired, 0);
      if (n == 14) chk("R3 not wrapped before last slot", wrapped, 0);
      if (n == 15) chk("R3 wrapped at last slot", wrapped, 1);
      if (n == 20) begin
        chk("R7 R13 trigger seen", trig_fired, 1);
        chk("R7 trigger slot", trig_idx, 4);
        chk("R11 break pulse high", brk_req, 1);
        chk("R4 range and equal modes", frozen, 0);
      end
      if (n == 21) chk("R11 break pulse one cycle", brk_req, 0);
      if (n == 22) chk("R8 still capturing", frozen, 0);
      if (n == 23) chk("R8 frozen after post count", frozen, 1);
    end
    chk("R8 write index held after freeze", wr_idx, 8);
    chk("R2 trigger slot held", trig_idx, 4);
    for (int i = 0; i < DEPTH; i++) rd(i, hist[slot_owner(i, 23)], "R2 R8 readout test A");

    // Test B: less-than OR equal, then status; post 0
    cfg(2, 32'h0010);
    cfg(4, 32'hAAAA);
    cfg(10, 32'h114);
    cfg(6, 32'h000F);
    cfg(11, 32'h0C2);
    cfg(1, 0);
    arm(1'b1);
    chk("R12 arm clears trig_fired", trig_fired, 0);
    chk("R12 arm clears frozen", frozen, 0);
    chk("R12 arm clears wrapped", wrapped, 0);
    chk("R12 arm clears trig_idx", trig_idx, 0);
    chk("R12 arm clears wr_idx", wr_idx, 0);
    for (int n = 0; n < 10; n++) begin
      a = 16'h0100 + 16'(n); d = 16'h2000 + 16'(n); s = {1'b0, 3'(n)};
      if (n == 3) d = 16'hAAAA;
      if (n == 6) s = 4'hF;
      send(a, d, s);
      if (n == 5) chk("R4 R5 OR level passed, no trigger yet", trig_fired, 0);
      if (n == 6) begin
        chk("R9 frozen on trigger sample", frozen, 1);
        chk("R9 trigger slot", trig_idx, 6);
        chk("R11 break pulse test B", brk_req, 1);
      end
    end
    chk("R9 write index after freeze", wr_idx, 7);
    chk("R3 no wrap in test B", wrapped, 0);
    for (int i = 0; i <= 6; i++) rd(i, hist[i], "R2 R9 readout test B");

    // Test C: address range, then data less-than; post 40 > depth; break off
    cfg(2, 32'h0100);
    cfg(3, 32'h0102);
    cfg(10, 32'h0C8);
    cfg(6, 32'h0005);
    cfg(11, 32'h0C5);
    cfg(1, 40);
    arm(1'b0);
    for (int n = 0; n < 48; n++) begin
      a = 16'h0100 + 16'(n); d = 16'h2000 + 16'(n); s = {1'b0, 3'(n)};
      if (n == 4) d = 16'h0001;
      if (n >= 45) d = 16'hBEEF;
      send(a, d, s);
      if (n == 4) begin
        chk("R4 inclusive range then less-than trigger", trig_fired, 1);
        chk("R11 no break when disabled", brk_req, 0);
        chk("R7 trigger slot test C", trig_idx, 4);
      end
      if (n == 43) chk("R10 still capturing", frozen, 0);
      if (n == 44) chk("R10 frozen after long post count", frozen, 1);
    end
    chk("R10 wrapped", wrapped, 1);
    chk("R10 write index", wr_idx, 13);
    chk("R10 trigger slot kept", trig_idx, 4);
    for (int i = 0; i < DEPTH; i++) rd(i, hist[slot_owner(i, 44)], "R10 readout test C");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule